// File: doc/BRIEF.md
# Network Interrupt Receive Queue (Coupled Data / Sender ID)

This block holds the network interrupts of one type that reach this node. Each qualifying packet leaves behind a 32-bit payload word and the 8-bit node ID of its sender. The payload and the ID go into two queues of equal depth. One head pointer serves both queues. Four instances, each with a different `MATCH_TYPE`, cover the four interrupt types. Packet transport and host interrupt signalling sit outside this block.

The host reads through two ports, picked by `host_sel_i`. Reading the data port returns the payload at the head and does not advance the head, so software can read that word as many times as it likes. Reading the ID port returns the sender ID at the head and pops both queues together. Software must therefore read the data word first. Any write to the ID port empties both queues. A read value of zero does not mean the queue is empty, because zero is a valid node ID, so emptiness is reported on its own output together with the entry count, a full flag and a sticky overflow flag.

Top module: `net_irq_rx_fifo`

## Requirements
- R1: After reset, `count_o` is 0, `empty_o` is 1, `full_o` is 0, `overflow_o` is 0 and `host_rdata_o` is 0.
- R2: A packet with `pkt_valid_i` high is stored only when `pkt_type_i` equals `MATCH_TYPE` and either `pkt_global_i` is 1 or `pkt_dest_i` equals `node_id_i`. Any other packet leaves the count and contents unchanged.
- R3: While the queue is not empty and `host_sel_i` is 0 (data port), `host_rdata_o` shows the payload at the head. Asserting `host_rd_i` on this port does not move the head, so repeated reads return the same word.
- R4: While the queue is not empty and `host_sel_i` is 1 (ID port), `host_rdata_o` shows the head sender ID in bits 7:0 with zeros above. A `host_rd_i` on this port pops the payload and the ID together. Entries leave in arrival order.
- R5: While the queue is empty, `host_rdata_o` is 0 on both ports, and a read does not change the count or the head.
- R6: A cycle with `host_wr_i` high and `host_sel_i` = 1 empties both queues and clears `overflow_o`, whatever packet arrives in that cycle.
- R7: A write with `host_sel_i` = 0 (data port) has no effect on the contents, the count or the flags.
- R8: The queue holds `DEPTH` (127) entries. A qualifying packet that arrives while `full_o` is 1 is dropped, even if a pop happens in the same cycle, and sets `overflow_o`. `overflow_o` stays set until a flush.
- R9: When a qualifying packet arrives and an ID-port pop happens in the same cycle on a queue that is neither empty nor full, both take effect and `count_o` stays the same.
- R10: `empty_o` is 1 exactly when `count_o` is 0. `full_o` is 1 exactly when `count_o` equals `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 8 | ID of this node |
| pkt_valid_i | input | 1 | Incoming packet present this cycle |
| pkt_global_i | input | 1 | Packet is delivered to all nodes |
| pkt_dest_i | input | 8 | Destination node ID of the packet |
| pkt_type_i | input | 3 | Interrupt type code of the packet |
| pkt_src_i | input | 8 | Sender node ID of the packet |
| pkt_data_i | input | 32 | Payload word of the packet |
| host_sel_i | input | 1 | Host port select: 0 = data, 1 = sender ID |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe (ID port: flush) |
| host_rdata_o | output | 32 | Read data of the selected port at the head |
| count_o | output | 7 | Number of stored entries |
| empty_o | output | 1 | No entries stored |
| full_o | output | 1 | DEPTH entries stored |
| overflow_o | output | 1 | Sticky: a qualifying packet was dropped |

## Verification
A wrong head pointer shows up at once as a wrong `host_rdata_o` value. If the data port moves the head, the next data read returns a different word. If the ID port fails to move it, the same ID is returned twice. A faulty count or faulty wrap arithmetic becomes visible at `count_o`, `empty_o` and `full_o` on the edge after the store or pop. A bad wrap inside the storage shows up after about one full pass of 127 entries, when the order of IDs breaks. The random phase runs long enough to wrap the pointers many times, and the bench compares every read against a reference queue.

// File: rtl/net_irq_rx_pkg.sv
package net_irq_rx_pkg;
  localparam int unsigned NODE_ID_W = 8;
  localparam int unsigned PAYLOAD_W = 32;
  localparam int unsigned IRQ_TYPE_W = 3;

  typedef enum logic {
    PORT_DATA = 1'b0,
    PORT_ID   = 1'b1
  } host_port_e;
endpackage

// File: rtl/nirx_match.sv
module nirx_match #(
  parameter int unsigned ID_W       = 8,
  parameter int unsigned TYPE_W     = 3,
  parameter logic [TYPE_W-1:0] MATCH_TYPE = 3'd1
) (
  input  logic              valid_i,
  input  logic              global_i,
  input  logic [ID_W-1:0]   dest_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [ID_W-1:0]   node_id_i,
  output logic              hit_o
);
  logic addr_ok;
  logic type_ok;

  assign addr_ok = global_i | (dest_i == node_id_i);
  assign type_ok = (type_i == MATCH_TYPE);
  assign hit_o   = valid_i & addr_ok & type_ok;
endmodule

// File: rtl/nirx_ptr_ctrl.sv
module nirx_ptr_ctrl #(
  parameter int unsigned DEPTH = 127,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_req_i,
  input  logic             pop_req_i,
  input  logic             flush_i,
  output logic             push_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  // full drops the arrival even if a pop happens in the same cycle
  assign do_push = push_req_i & ~full_o & ~flush_i;
  assign do_pop  = pop_req_i & ~empty_o & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_req_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign push_o   = do_push;
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/nirx_store.sv
module nirx_store #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 127,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/net_irq_rx_fifo.sv
module net_irq_rx_fifo
  import net_irq_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 127,
  parameter logic [IRQ_TYPE_W-1:0] MATCH_TYPE = 3'd1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NODE_ID_W-1:0]        node_id_i,
  input  logic                        pkt_valid_i,
  input  logic                        pkt_global_i,
  input  logic [NODE_ID_W-1:0]        pkt_dest_i,
  input  logic [IRQ_TYPE_W-1:0]       pkt_type_i,
  input  logic [NODE_ID_W-1:0]        pkt_src_i,
  input  logic [PAYLOAD_W-1:0]        pkt_data_i,
  input  logic                        host_sel_i,
  input  logic                        host_rd_i,
  input  logic                        host_wr_i,
  output logic [PAYLOAD_W-1:0]        host_rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]  count_o,
  output logic                        empty_o,
  output logic                        full_o,
  output logic                        overflow_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  host_port_e       port;
  logic             pkt_hit;
  logic             flush, pop_req, push_en;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PAYLOAD_W-1:0] head_data;
  logic [NODE_ID_W-1:0] head_id;
  logic [CNT_W-1:0] cnt;
  logic             empty, full, ovf;

  assign port    = host_port_e'(host_sel_i);
  assign flush   = host_wr_i & (port == PORT_ID);
  assign pop_req = host_rd_i & (port == PORT_ID);

  nirx_match #(
    .ID_W      (NODE_ID_W),
    .TYPE_W    (IRQ_TYPE_W),
    .MATCH_TYPE(MATCH_TYPE)
  ) u_match (
    .valid_i  (pkt_valid_i),
    .global_i (pkt_global_i),
    .dest_i   (pkt_dest_i),
    .type_i   (pkt_type_i),
    .node_id_i(node_id_i),
    .hit_o    (pkt_hit)
  );

  nirx_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_req_i(pkt_hit),
    .pop_req_i (pop_req),
    .flush_i   (flush),
    .push_o    (push_en),
    .wr_ptr_o  (wr_ptr),
    .rd_ptr_o  (rd_ptr),
    .count_o   (cnt),
    .empty_o   (empty),
    .full_o    (full),
    .ovf_o     (ovf)
  );

  nirx_store #(.WIDTH(PAYLOAD_W), .DEPTH(DEPTH)) u_data_q (
    .clk_i  (clk_i),
    .we_i   (push_en),
    .waddr_i(wr_ptr),
    .wdata_i(pkt_data_i),
    .raddr_i(rd_ptr),
    .rdata_o(head_data)
  );

  nirx_store #(.WIDTH(NODE_ID_W), .DEPTH(DEPTH)) u_id_q (
    .clk_i  (clk_i),
    .we_i   (push_en),
    .waddr_i(wr_ptr),
    .wdata_i(pkt_src_i),
    .raddr_i(rd_ptr),
    .rdata_o(head_id)
  );

  always_comb begin
    host_rdata_o = '0;
    if (!empty) begin
      if (port == PORT_ID) host_rdata_o = {{(PAYLOAD_W-NODE_ID_W){1'b0}}, head_id};
      else                 host_rdata_o = head_data;
    end
  end

  assign count_o    = cnt;
  assign empty_o    = empty;
  assign full_o     = full;
  assign overflow_o = ovf;
endmodule

// File: rtl/nirx_checker.sv
module nirx_checker #(
  parameter int unsigned DEPTH = 127,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_valid_i,
  input logic             hit_i,
  input logic             host_sel_i,
  input logic             host_rd_i,
  input logic             host_wr_i,
  input logic [31:0]      host_rdata_o,
  input logic [CNT_W-1:0] count_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             overflow_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assert_empty_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (count_o == '0));
  assert_full_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (count_o == FULL_CNT));
  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
  assert_no_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !host_wr_i && !(host_rd_i && host_sel_i)) |=> $stable(count_o));
  assert_data_read_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pkt_valid_i && !host_wr_i && host_rd_i && !host_sel_i) |=> $stable(count_o));
  assert_id_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pkt_valid_i && !host_wr_i && host_rd_i && host_sel_i && !empty_o)
      |=> count_o == $past(count_o) - 1'b1);
  assert_empty_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> host_rdata_o == '0);
  assert_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_sel_i) |=> (empty_o && !overflow_o));
  assert_data_wr_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pkt_valid_i && host_wr_i && !host_sel_i && !host_rd_i)
      |=> ($stable(count_o) && $stable(overflow_o)));
  assert_overflow_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && full_o && !(host_wr_i && host_sel_i)) |=> overflow_o);
  assert_overflow_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !(host_wr_i && host_sel_i)) |=> overflow_o);
  assert_push_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !full_o && !empty_o && host_rd_i && host_sel_i && !host_wr_i)
      |=> $stable(count_o));
endmodule

bind net_irq_rx_fifo nirx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_valid_i (pkt_valid_i),
  .hit_i       (pkt_hit),
  .host_sel_i  (host_sel_i),
  .host_rd_i   (host_rd_i),
  .host_wr_i   (host_wr_i),
  .host_rdata_o(host_rdata_o),
  .count_o     (count_o),
  .empty_o     (empty_o),
  .full_o      (full_o),
  .overflow_o  (overflow_o)
);

// File: tb/sim_net_irq_rx_fifo.sv
`timescale 1ns/1ps
module sim_net_irq_rx_fifo;
  localparam int DEPTH = 127;
  localparam logic [7:0] MY_ID = 8'h2A;
  localparam logic [2:0] MY_TYPE = 3'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 0, pkt_global = 0;
  logic [7:0]  pkt_dest = 0, pkt_src = 0;
  logic [2:0]  pkt_type = 0;
  logic [31:0] pkt_data = 0;
  logic        host_sel = 0, host_rd = 0, host_wr = 0;
  logic [31:0] host_rdata;
  logic [6:0]  count;
  logic        empty, full, overflow;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [39:0] mq[$];
  bit m_ovf = 0;

  always #4 clk = ~clk;

  net_irq_rx_fifo #(.DEPTH(DEPTH), .MATCH_TYPE(MY_TYPE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .node_id_i(MY_ID),
    .pkt_valid_i(pkt_valid), .pkt_global_i(pkt_global), .pkt_dest_i(pkt_dest),
    .pkt_type_i(pkt_type), .pkt_src_i(pkt_src), .pkt_data_i(pkt_data),
    .host_sel_i(host_sel), .host_rd_i(host_rd), .host_wr_i(host_wr),
    .host_rdata_o(host_rdata), .count_o(count), .empty_o(empty),
    .full_o(full), .overflow_o(overflow));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit hits(input bit v, input bit g, input logic [7:0] d, input logic [2:0] t);
    return v && (t == MY_TYPE) && (g || d == MY_ID);
  endfunction

  function automatic logic [31:0] exp_rdata(input bit sel);
    if (mq.size() == 0) return 32'h0;
    return sel ? {24'h0, mq[0][7:0]} : mq[0][39:8];
  endfunction

  task automatic step(input bit v, input bit g, input logic [7:0] d, input logic [2:0] t,
                      input logic [7:0] s, input logic [31:0] dat,
                      input bit sel, input bit rd, input bit wr);
    bit hit, was_full;
    pkt_valid = v; pkt_global = g; pkt_dest = d; pkt_type = t;
    pkt_src = s; pkt_data = dat; host_sel = sel; host_rd = rd; host_wr = wr;
    #1;
    if (rd) begin
      if (mq.size() == 0) chk("R5 empty read", host_rdata, 32'h0);
      else if (sel)       chk("R4 id head", host_rdata, exp_rdata(1));
      else                chk("R3 data head", host_rdata, exp_rdata(0));
    end
    @(posedge clk);
    hit = hits(v, g, d, t);
    was_full = (mq.size() == DEPTH);
    if (wr && sel) begin
      mq.delete(); m_ovf = 0;
    end else begin
      if (hit && was_full) m_ovf = 1;
      if (rd && sel && mq.size() > 0) void'(mq.pop_front());
      if (hit && !was_full) mq.push_back({dat, s});
    end
    @(negedge clk);
    pkt_valid = 0; host_rd = 0; host_wr = 0;
    chk("R10 count", {25'h0, count}, mq.size());
    chk("R10 empty", {31'h0, empty}, mq.size() == 0);
    chk("R10 full", {31'h0, full}, mq.size() == DEPTH);
    chk("R8 overflow", {31'h0, overflow}, m_ovf);
  endtask

  task automatic push(input logic [7:0] s, input logic [31:0] dat);
    step(1, 0, MY_ID, MY_TYPE, s, dat, 0, 0, 0);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240917;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", {25'h0, count}, 0);
    chk("R1 empty", {31'h0, empty}, 1);
    chk("R1 full", {31'h0, full}, 0);
    chk("R1 overflow", {31'h0, overflow}, 0);
    chk("R1 rdata", host_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 empty reads on both ports
    step(0, 0, 0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R2 filtering
    step(1, 0, MY_ID, 3'd2, 8'h11, 32'hBAD0_0001, 0, 0, 0);
    step(1, 0, 8'h07, MY_TYPE, 8'h12, 32'hBAD0_0002, 0, 0, 0);
    step(1, 1, 8'h07, 3'd7, 8'h13, 32'hBAD0_0003, 0, 0, 0);
    chk("R2 rejected", {25'h0, count}, 0);
    step(1, 1, 8'h07, MY_TYPE, 8'h00, 32'hCAFE_0001, 0, 0, 0);
    push(8'h05, 32'hCAFE_0002);
    push(8'hFF, 32'hCAFE_0003);
    chk("R2 accepted", {25'h0, count}, 3);

    // R3 repeated data reads
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R3 no move", {25'h0, count}, 3);
    // R7 data port write ignored
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7 count", {25'h0, count}, 3);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R4 pop with id zero at head
    step(0, 0, 0, 0, 0, 0, 1, 1, 0);
    chk("R4 pop", {25'h0, count}, 2);
    // R9 simultaneous push and pop
    step(1, 0, MY_ID, MY_TYPE, 8'h44, 32'hCAFE_0004, 1, 1, 0);
    chk("R9 count held", {25'h0, count}, 2);

    // R8 fill, drop, sticky
    while (mq.size() < DEPTH) push(8'(mq.size()), $urandom);
    chk("R8 full", {31'h0, full}, 1);
    push(8'h99, 32'hDEAD_BEEF);
    step(1, 0, MY_ID, MY_TYPE, 8'h9A, 32'hDEAD_BEE0, 1, 1, 0);
    chk("R8 dropped", {25'h0, count}, DEPTH - 1);
    chk("R8 sticky", {31'h0, overflow}, 1);
    idle();
    // drain a few to confirm order after wrap
    repeat (5) step(0, 0, 0, 0, 0, 0, 1, 1, 0);

    // R6 flush with concurrent qualifying packet
    step(1, 0, MY_ID, MY_TYPE, 8'h77, 32'h1234_5678, 1, 0, 1);
    chk("R6 flushed", {25'h0, count}, 0);
    chk("R6 ovf cleared", {31'h0, overflow}, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      bit v, g, sel, rd, wr;
      logic [7:0] d;
      logic [2:0] t;
      v   = ($urandom % 10) < 6;
      g   = ($urandom % 5) == 0;
      d   = ($urandom % 4) != 0 ? MY_ID : 8'($urandom);
      t   = ($urandom % 2) != 0 ? MY_TYPE : 3'($urandom);
      sel = $urandom % 2;
      rd  = ($urandom % 10) < 4;
      wr  = ($urandom % 200) == 0;
      step(v, g, d, t, 8'($urandom), $urandom, sel, rd, wr);
    end
    finish_run();
  end
endmodule